// File: doc/BRIEF.md
# Interpolating DAC Data-Clock Divider

This block runs on the fast converter clock and derives two slower timing signals from it. One is a single-cycle sampling enable that tells the input datapath when to capture a new sample. The other is an exported data clock that an upstream source can use to launch its data. Both rates come from configuration fields: an interpolation factor (1, 2, 4 or 8), a zero-stuffing enable that doubles the ratio, and a port-width select where single-port mode halves the ratio. A separate output-only divide of 1, 2 or 4 stretches the exported clock period and leaves the sampling enable alone.

Every divide ratio is a power of two, so one free-running counter produces both outputs. An asynchronous sync input is brought onto the fast clock through a flop chain. Its rising edge restarts the counter, which fixes the sampling phase against a known reference edge and removes the phase ambiguity of a free-running divider. New settings are written through a parallel address/data port. They take effect only when the exported clock period completes, so neither output ever shows a shortened pulse.

Top module: `dclk_divider`

## Requirements
- R1: After reset every configuration field is zero (interpolation 1, zero stuffing off, dual port, output divide 1). While reset is held, `sample_en`, `dclk_out` and `cfg_err` are 0. From the second clock after release, `sample_en` is high on every cycle and `dclk_out` is held high.
- R2: The sampling divisor D equals interpolation × zero-stuff × port factor. Interpolation is set by bits [7:6] of address 0x01, where codes 0..3 select 1, 2, 4 and 8. Bit [0] of 0x01 set to 1 selects a zero-stuff factor of 2. Bit [6] of 0x02 set to 1 selects single port (factor 0.5); 0 selects dual port (factor 1). `sample_en` is a one-cycle pulse every D clocks, or stays high when D is 1.
- R3: Bits [5:4] of address 0x03 select an output divide of 1, 2 or 4 for codes 00, 01 and 10; code 11 also selects 4. The `dclk_out` period is D times this value. The spacing of `sample_en` does not depend on this field.
- R4: `dclk_out` goes high when the shared counter restarts and stays high for ceil(P/2) clocks of its period P. When P is 1 it is held high.
- R5: A setting whose ratio falls below 1 (interpolation code 0, zero stuffing off, single port) raises `cfg_err` while it is held. It is never applied: the previous divisors stay active.
- R6: `sync_in` is synchronised through two flops and its rising edge is detected. The counter restarts at the third clock edge after `sync_in` rises. `dclk_out` goes high at that edge. When D > 1, `sample_en` is low until it pulses exactly D clocks after the restart, and it repeats every D clocks after that.
- R7: Settings written mid-period do not alter either output until the current `dclk_out` period completes. The new divisors take effect from that wrap edge.
- R8: Writes to addresses other than 0x01, 0x02 and 0x03, and written bits outside the fields above, have no effect on either output.
- R9: Holding `sync_in` high restarts the counter only once. The divider then keeps running at its configured rates.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast converter clock |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration register address |
| cfg_wdata | input | DATA_W | Configuration write data |
| sync_in | input | 1 | Asynchronous phase-alignment request |
| sample_en | output | 1 | Sampling enable pulse, one per sampling period |
| dclk_out | output | 1 | Exported data clock |
| cfg_err | output | 1 | Written setting has a ratio below 1 |

## Verification
Several corner cases are targeted directly.

- **Half-factor cases.** Single-port settings with a ratio of exactly 1 are exercised. A design that mishandled the half factor would show gaps in an always-high enable.
- **Illegal setting.** An illegal setting is written from a running state of ratio 1. A design that applied it would drive the divider from a wrapped-around exponent and lose the every-cycle enable.
- **Mid-period write.** A divisor change lands in the middle of a long period. A design that loaded it immediately would pulse early and shorten the exported clock.
- **Reserved code and stray writes.** The reserved output-divide code is driven, along with writes to foreign addresses and non-field bits. A design that decoded too few address bits, or stored stray bits, would change its periods.
- **Held sync.** `sync_in` stays high through each measurement window. A design that acted on the level instead of the edge would freeze the counter.

// File: rtl/dclkdiv_pkg.sv
package dclkdiv_pkg;

   // log2 of the largest sampling divisor: interp 8 x zero-stuff 2 x dual 1
   localparam int MAX_SAMP_L2 = 4;
   // log2 of the largest output-only divide
   localparam int MAX_XDIV_L2 = 2;
   // width holding any log2 ratio
   localparam int L2_W        = 3;
   // counter spans the full exported period
   localparam int CNT_W       = MAX_SAMP_L2 + MAX_XDIV_L2;

   typedef struct packed {
      logic [1:0] interp_code;
      logic       zstuff;
      logic       single_port;
      logic [1:0] xdiv_code;
   } dd_cfg_t;

   // output-divide code to log2 ratio; the reserved code behaves as divide-by-4
   function automatic logic [L2_W-1:0] xdiv_log2(input logic [1:0] code);
      case (code)
         2'b00:   return L2_W'(0);
         2'b01:   return L2_W'(1);
         default: return L2_W'(2);
      endcase
   endfunction

   // log2 of twice the sampling divisor; zero means a ratio of one half
   function automatic logic [L2_W-1:0] twice_samp_log2(input dd_cfg_t c);
      return L2_W'(c.interp_code) + L2_W'(c.zstuff) + L2_W'(!c.single_port);
   endfunction

endpackage

// File: rtl/dd_cfg_regs.sv
module dd_cfg_regs
   import dclkdiv_pkg::*;
#(
   parameter int                ADDR_W    = 8,
   parameter int                DATA_W    = 8,
   parameter logic [ADDR_W-1:0] ADDR_MODE = 'h01,
   parameter logic [ADDR_W-1:0] ADDR_PORT = 'h02,
   parameter logic [ADDR_W-1:0] ADDR_DCLK = 'h03
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output dd_cfg_t           cfg
);

   if (DATA_W < 8) begin : g_bad_width
      $error("dd_cfg_regs: DATA_W must be at least 8");
   end

   logic unused_wdata;
   assign unused_wdata = ^wr_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            ADDR_MODE: begin
               cfg.interp_code <= wr_data[7:6];
               cfg.zstuff      <= wr_data[0];
            end
            ADDR_PORT: cfg.single_port <= wr_data[6];
            ADDR_DCLK: cfg.xdiv_code   <= wr_data[5:4];
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/dd_sync_edge.sv
module dd_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);

   if (STAGES < 2) begin : g_bad_stages
      $error("dd_sync_edge: STAGES must be at least 2");
   end

   logic chain [STAGES];
   logic last_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= chain[STAGES-1];
   end

   assign rise = chain[STAGES-1] & ~last_q;

endmodule

// File: rtl/dd_div_core.sv
module dd_div_core
   import dclkdiv_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  dd_cfg_t          pend_cfg,
   input  logic             sync_rise,
   output logic             sample_en,
   output logic             dclk,
   output logic             cfg_err,
   output logic             wrap,
   output logic [CNT_W-1:0] cnt,
   output logic [L2_W-1:0]  act_sl2,
   output logic [L2_W-1:0]  act_xl2
);

   localparam logic [CNT_W:0] ONE_W = (CNT_W+1)'(1);

   logic [L2_W-1:0]  twice_l2, pend_sl2, pend_xl2, tot_l2;
   logic             pend_ok;
   logic [CNT_W:0]   period, half_up, samp_per;
   logic [CNT_W-1:0] last_cnt, smask, cnt_next;

   // pending setting decoded to log2 ratios
   assign twice_l2 = twice_samp_log2(pend_cfg);
   assign pend_ok  = (twice_l2 != '0);
   assign pend_sl2 = twice_l2 - L2_W'(1);
   assign pend_xl2 = xdiv_log2(pend_cfg.xdiv_code);
   assign cfg_err  = !pend_ok;

   // active ratios
   assign tot_l2   = act_sl2 + act_xl2;
   assign period   = ONE_W << tot_l2;
   assign half_up  = (period + ONE_W) >> 1;
   assign last_cnt = CNT_W'(period - ONE_W);
   assign samp_per = ONE_W << act_sl2;
   assign smask    = CNT_W'(samp_per - ONE_W);

   assign wrap     = (cnt == last_cnt);
   assign cnt_next = (sync_rise || wrap) ? '0 : cnt + CNT_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt       <= '0;
         act_sl2   <= '0;
         act_xl2   <= '0;
         sample_en <= 1'b0;
         dclk      <= 1'b0;
      end else begin
         cnt  <= cnt_next;
         dclk <= ({1'b0, cnt_next} < half_up);
         if (sync_rise) sample_en <= (act_sl2 == '0);
         else           sample_en <= ((cnt & smask) == smask);
         if (wrap && pend_ok) begin
            act_sl2 <= pend_sl2;
            act_xl2 <= pend_xl2;
         end
      end
   end

endmodule

// File: rtl/dclk_divider.sv
module dclk_divider
   import dclkdiv_pkg::*;
#(
   parameter int                ADDR_W      = 8,
   parameter int                DATA_W      = 8,
   parameter int                SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] ADDR_MODE   = 'h01,
   parameter logic [ADDR_W-1:0] ADDR_PORT   = 'h02,
   parameter logic [ADDR_W-1:0] ADDR_DCLK   = 'h03
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr_en,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic              sync_in,
   output logic              sample_en,
   output logic              dclk_out,
   output logic              cfg_err
);

   dd_cfg_t          pend_cfg;
   logic             sync_rise;
   logic             core_wrap;
   logic [CNT_W-1:0] core_cnt;
   logic [L2_W-1:0]  act_sl2, act_xl2;

   dd_cfg_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .ADDR_MODE(ADDR_MODE), .ADDR_PORT(ADDR_PORT), .ADDR_DCLK(ADDR_DCLK)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en),
      .wr_addr(cfg_addr), .wr_data(cfg_wdata), .cfg(pend_cfg)
   );

   dd_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(sync_in), .rise(sync_rise)
   );

   dd_div_core u_core (
      .clk(clk), .rst_n(rst_n), .pend_cfg(pend_cfg), .sync_rise(sync_rise),
      .sample_en(sample_en), .dclk(dclk_out), .cfg_err(cfg_err),
      .wrap(core_wrap), .cnt(core_cnt), .act_sl2(act_sl2), .act_xl2(act_xl2)
   );

endmodule

// File: rtl/dd_div_checker.sv
module dd_div_checker
   import dclkdiv_pkg::*;
(
   input logic             clk,
   input logic             rst_n,
   input logic             sync_rise,
   input logic             wrap,
   input logic [CNT_W-1:0] cnt,
   input logic [L2_W-1:0]  act_sl2,
   input logic [L2_W-1:0]  act_xl2,
   input logic             sample_en,
   input logic             cfg_err
);

   logic [L2_W:0]  tot_chk;
   logic [CNT_W:0] span_chk;
   assign tot_chk  = {1'b0, act_sl2} + {1'b0, act_xl2};
   assign span_chk = (CNT_W+1)'(1) << tot_chk;

   // R2: between pulses the enable drops when the sampling divisor exceeds 1
   p_sample_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_en && act_sl2 != '0 && !sync_rise && !wrap) |=> !sample_en);

   // R4: counter never leaves the active exported period
   p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, cnt} < span_chk));

   // R5: an illegal pending setting never reaches the active ratios
   p_err_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |=> ($stable(act_sl2) && $stable(act_xl2)));

   // R6: a detected sync edge restarts the counter
   p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sync_rise |=> (cnt == '0));

   // R7: active ratios move only at a period wrap
   p_hold_cfg_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap |=> ($stable(act_sl2) && $stable(act_xl2)));

endmodule

bind dclk_divider dd_div_checker u_chk (
   .clk(clk), .rst_n(rst_n), .sync_rise(sync_rise), .wrap(core_wrap),
   .cnt(core_cnt), .act_sl2(act_sl2), .act_xl2(act_xl2),
   .sample_en(sample_en), .cfg_err(cfg_err)
);

// File: tb/dclk_divider_test.sv
module dclk_divider_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_wr_en = 1'b0;
   logic [7:0] cfg_addr = '0;
   logic [7:0] cfg_wdata = '0;
   logic       sync_in = 1'b0;
   logic       sample_en, dclk_out, cfg_err;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   dclk_divider uut (
      .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .sync_in(sync_in), .sample_en(sample_en),
      .dclk_out(dclk_out), .cfg_err(cfg_err)
   );

   // {interp code, zero stuff, single port, out-div code, 2'b0, D, P, H}
   localparam logic [31:0] VEC [0:7] = '{
      {2'd1, 1'b0, 1'b0, 2'd0, 2'd0, 8'd2,  8'd2,  8'd1},
      {2'd2, 1'b1, 1'b0, 2'd1, 2'd0, 8'd8,  8'd16, 8'd8},
      {2'd3, 1'b1, 1'b0, 2'd2, 2'd0, 8'd16, 8'd64, 8'd32},
      {2'd1, 1'b0, 1'b1, 2'd0, 2'd0, 8'd1,  8'd1,  8'd1},
      {2'd0, 1'b1, 1'b1, 2'd2, 2'd0, 8'd1,  8'd4,  8'd2},
      {2'd3, 1'b0, 1'b1, 2'd3, 2'd0, 8'd4,  8'd16, 8'd8},
      {2'd2, 1'b0, 1'b0, 2'd0, 2'd0, 8'd4,  8'd4,  8'd2},
      {2'd0, 1'b0, 1'b0, 2'd1, 2'd0, 8'd1,  8'd2,  8'd1}
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_wr_en = 1'b0;
   endtask

   // raise sync, hold it, and compare both outputs over two long periods
   task automatic measure(input int d, input int p, input int h, input string tag);
      int se_bad = 0, se_act = 0, se_exp = 0;
      int dc_bad = 0, dc_act = 0, dc_exp = 0;
      @(negedge clk);
      sync_in = 1'b1;
      for (int k = 1; k <= 133; k++) begin
         @(negedge clk);
         if (k >= 3) begin
            int e_se, e_dc;
            e_se = (k == 3) ? int'(d == 1) : int'(((k - 3) % d) == 0);
            e_dc = int'(((k - 3) % p) < h);
            if (int'(sample_en) != e_se && se_bad == 0) begin
               se_bad = k; se_act = int'(sample_en); se_exp = e_se;
            end
            if (int'(dclk_out) != e_dc && dc_bad == 0) begin
               dc_bad = k; dc_act = int'(dclk_out); dc_exp = e_dc;
            end
         end
      end
      sync_in = 1'b0;
      repeat (4) @(negedge clk);
      check(se_bad == 0, {tag, " R2 R6 R9 sample_en"}, se_act, se_exp);
      check(dc_bad == 0, {tag, " R3 R4 dclk_out"}, dc_act, dc_exp);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check(!sample_en && !dclk_out && !cfg_err, "R1 outputs in reset",
            int'({sample_en, dclk_out, cfg_err}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      begin
         int bad = 0;
         for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (!sample_en || !dclk_out || cfg_err) bad++;
         end
         check(bad == 0, "R1 default divide-by-1", bad, 0);
      end

      // table of settings
      for (int i = 0; i < 8; i++) begin
         logic [31:0] v;
         v = VEC[i];
         wr(8'h01, {v[31:30], 5'b0, v[29]});
         wr(8'h02, {1'b0, v[28], 6'b0});
         wr(8'h03, {2'b0, v[27:26], 4'b0});
         repeat (80) @(negedge clk);
         check(!cfg_err, "R2 legal setting flag", int'(cfg_err), 0);
         measure(int'(v[23:16]), int'(v[15:8]), int'(v[7:0]), $sformatf("vec%0d", i));
      end

      // R5: illegal setting from a ratio-1 state
      wr(8'h01, 8'h01);
      wr(8'h02, 8'h40);
      wr(8'h03, 8'h20);
      repeat (80) @(negedge clk);
      wr(8'h01, 8'h00);
      check(cfg_err, "R5 flag raised", int'(cfg_err), 1);
      repeat (80) @(negedge clk);
      measure(1, 4, 2, "R5 kept previous");
      wr(8'h01, 8'h01);
      check(!cfg_err, "R5 flag cleared", int'(cfg_err), 0);

      // R7: change written mid-period (D 8 -> 2, P 8 -> 2)
      wr(8'h01, 8'hC0);
      wr(8'h02, 8'h00);
      wr(8'h03, 8'h00);
      repeat (80) @(negedge clk);
      begin
         int bad = 0, b_act = 0, b_exp = 0;
         @(negedge clk);
         sync_in = 1'b1;
         for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            if (k == 4) begin
               cfg_wr_en = 1'b1; cfg_addr = 8'h01; cfg_wdata = 8'h40;
            end
            if (k == 5) cfg_wr_en = 1'b0;
            if (k >= 4) begin
               int e_se, e_dc;
               e_se = (k < 11) ? 0 : int'(((k - 11) % 2) == 0);
               e_dc = (k < 11) ? int'(k <= 6) : int'(((k - 11) % 2) == 0);
               if ((int'(sample_en) != e_se || int'(dclk_out) != e_dc) && bad == 0) begin
                  bad = k; b_act = int'({sample_en, dclk_out}); b_exp = (e_se * 2) + e_dc;
               end
            end
         end
         sync_in = 1'b0;
         repeat (4) @(negedge clk);
         check(bad == 0, "R7 load at wrap only", b_act, b_exp);
      end

      // R8: stray addresses and non-field bits
      wr(8'h01, 8'h80);
      wr(8'h02, 8'h00);
      wr(8'h03, 8'h10);
      repeat (80) @(negedge clk);
      wr(8'h04, 8'hFF);
      wr(8'h00, 8'hFF);
      wr(8'h81, 8'hFF);
      wr(8'h01, 8'hBE);
      wr(8'h02, 8'hBF);
      wr(8'h03, 8'hDF);
      repeat (80) @(negedge clk);
      check(!cfg_err, "R8 flag unaffected", int'(cfg_err), 0);
      measure(4, 8, 4, "R8 stray writes");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule